// File: doc/BRIEF.md
# Pipelined Data Output Phaser

The phaser takes one 14-bit conversion result per pixel period and delays it through a fixed pipeline of sixteen pixel periods. Each delayed word is then placed on the output bus at a chosen phase position within its pixel period. An output data clock is produced alongside the bus, and the position of its rising edge is set separately. An external 6-bit phase counter splits each pixel period into 64 ticks of the fast phase clock. The counter steps by one per clock and wraps from 63 to 0.

A single 12-bit configuration word carries both positions. The low field says when the data word changes, and this tick is also where the output clock falls. The high field says where the output clock rises. Raising the data-change field moves the change later within the pixel period, so the total delay grows smoothly from 16 × 64 ticks upward. A flag travels with every word, so the first sixteen periods after reset, and any pixel whose sample was not valid, show up as zero words with the flag low.

Top module: `dphase_top`

## Requirements
- R1: While `rst_n` is low, `dout` is zero, `dout_valid` is 0 and `dclk` is 0.
- R2: `smp_vld` and `smp_data` are taken only at a clock edge where `phase_cnt` is 0. At any other edge they have no effect on any later output.
- R3: A sample taken in pixel period P is launched at the edge in period P+16 where `phase_cnt` equals the data-change field. `dout` and `dout_valid` keep their values at every other edge.
- R4: `phase_cfg[5:0]` is the data-change field and `phase_cfg[11:6]` is the clock-rise field. Each field accepts any value from 0 to 63.
- R5: A launched slot whose sample was valid drives its data with `dout_valid` = 1. A slot with no valid sample, including every slot in the first 16 periods after reset, drives zero with `dout_valid` = 0.
- R6: `dclk` is 1 after an edge where `phase_cnt` equals the clock-rise field and the two fields differ. It rises at no other edge.
- R7: `dclk` is 0 after an edge where `phase_cnt` equals the data-change field. When the two fields are equal, `dclk` stays 0.
- R8: With the data-change field at 0, the launch happens at the same edge that advances the pipeline, and the delay is exactly 16 × 64 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast phase clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| phase_cnt | input | 6 | Phase position within the pixel period, stepping 0..63 |
| phase_cfg | input | 12 | [11:6] clock-rise position, [5:0] data-change position |
| smp_vld | input | 1 | Sample-valid strobe, taken at phase 0 |
| smp_data | input | 14 | Conversion result, taken at phase 0 |
| dout | output | 14 | Phased output data word |
| dout_valid | output | 1 | Marks a word that came from a valid sample |
| dclk | output | 1 | Output data clock |

## Verification
Each registered output is due one edge after its cause. The bench samples 5 ns after every rising edge and updates its expected `dout` and `dout_valid` only when the phase just applied matched the data-change field. The launched word is the one the bench recorded at phase 0 of pixel period P−16, where P is the period of that edge. The expected `dclk` is set or cleared on the same edge, using the phase just applied, with the data-change field taking precedence. Because every cycle is compared, an early or late launch by even one tick is caught, and so is a change caused by inputs driven at non-zero phases.

// File: rtl/dphase_pkg.sv
package dphase_pkg;
  localparam int unsigned DEF_DATA_W = 14;
  localparam int unsigned DEF_PH_W   = 6;
  localparam int unsigned DEF_DEPTH  = 16;
endpackage

// File: rtl/dphase_pipe.sv
module dphase_pipe #(
  parameter int unsigned DATA_W = dphase_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = dphase_pkg::DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              tail_vld,
  output logic [DATA_W-1:0] tail_data,
  output logic              hold_vld,
  output logic [DATA_W-1:0] hold_data
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DATA_W-1:0] stg_d_q [DEPTH];
  logic [DATA_W-1:0] stg_d_n [DEPTH];
  logic [DEPTH-1:0]  stg_v_q;
  logic [DEPTH-1:0]  stg_v_n;
  logic [DATA_W-1:0] hold_d_q;
  logic              hold_v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        stg_d_n[g] = in_data;
        stg_v_n[g] = in_vld;
      end
    end else begin : g_body
      always_comb begin
        stg_d_n[g] = stg_d_q[g-1];
        stg_v_n[g] = stg_v_q[g-1];
      end
    end
  end

  // data words carry no reset; the valid bits qualify them
  always_ff @(posedge clk) begin
    if (adv) begin
      stg_d_q  <= stg_d_n;
      hold_d_q <= stg_d_q[LAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q  <= '0;
      hold_v_q <= 1'b0;
    end else if (adv) begin
      stg_v_q  <= stg_v_n;
      hold_v_q <= stg_v_q[LAST];
    end
  end

  assign tail_vld  = stg_v_q[LAST];
  assign tail_data = stg_d_q[LAST];
  assign hold_vld  = hold_v_q;
  assign hold_data = hold_d_q;
endmodule

// File: rtl/dphase_launch.sv
module dphase_launch #(
  parameter int unsigned DATA_W = dphase_pkg::DEF_DATA_W,
  parameter int unsigned PH_W   = dphase_pkg::DEF_PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_cnt,
  input  logic [PH_W-1:0]   chg_ph,
  input  logic              tail_vld,
  input  logic [DATA_W-1:0] tail_data,
  input  logic              hold_vld,
  input  logic [DATA_W-1:0] hold_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic              ld_en;
  logic              src_v;
  logic [DATA_W-1:0] src_d;
  logic [DATA_W-1:0] dout_n;
  logic [DATA_W-1:0] dout_q;
  logic              vld_q;

  always_comb begin
    ld_en = (phase_cnt == chg_ph);
    // at phase 0 the pipeline shifts on this same edge: take the tail directly
    if (chg_ph == '0) begin
      src_v = tail_vld;
      src_d = tail_data;
    end else begin
      src_v = hold_vld;
      src_d = hold_data;
    end
    dout_n = src_v ? src_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else if (ld_en) begin
      dout_q <= dout_n;
      vld_q  <= src_v;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = vld_q;
endmodule

// File: rtl/dphase_dclk.sv
module dphase_dclk #(
  parameter int unsigned PH_W = dphase_pkg::DEF_PH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_cnt,
  input  logic [PH_W-1:0] chg_ph,
  input  logic [PH_W-1:0] rise_ph,
  output logic            dclk
);
  logic at_fall;
  logic at_rise;
  logic clk_en;
  logic dclk_n;
  logic dclk_q;

  always_comb begin
    at_fall = (phase_cnt == chg_ph);
    at_rise = (phase_cnt == rise_ph);
    clk_en  = at_fall | at_rise;
    dclk_n  = !at_fall;   // fall wins when both positions coincide
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dclk_q <= 1'b0;
    else if (clk_en) dclk_q <= dclk_n;
  end

  assign dclk = dclk_q;
endmodule

// File: rtl/dphase_top.sv
module dphase_top #(
  parameter int unsigned DATA_W = dphase_pkg::DEF_DATA_W,
  parameter int unsigned PH_W   = dphase_pkg::DEF_PH_W,
  parameter int unsigned DEPTH  = dphase_pkg::DEF_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PH_W-1:0]     phase_cnt,
  input  logic [2*PH_W-1:0]   phase_cfg,
  input  logic                smp_vld,
  input  logic [DATA_W-1:0]   smp_data,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_valid,
  output logic                dclk
);
  logic [PH_W-1:0]   chg_ph;
  logic [PH_W-1:0]   rise_ph;
  logic              adv;
  logic              tail_vld;
  logic [DATA_W-1:0] tail_data;
  logic              hold_vld;
  logic [DATA_W-1:0] hold_data;

  assign chg_ph  = phase_cfg[PH_W-1:0];
  assign rise_ph = phase_cfg[2*PH_W-1:PH_W];
  assign adv     = (phase_cnt == '0);

  dphase_pipe #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_vld(smp_vld), .in_data(smp_data),
    .tail_vld(tail_vld), .tail_data(tail_data),
    .hold_vld(hold_vld), .hold_data(hold_data)
  );

  dphase_launch #(.DATA_W(DATA_W), .PH_W(PH_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .phase_cnt(phase_cnt), .chg_ph(chg_ph),
    .tail_vld(tail_vld), .tail_data(tail_data),
    .hold_vld(hold_vld), .hold_data(hold_data),
    .dout(dout), .dout_valid(dout_valid)
  );

  dphase_dclk #(.PH_W(PH_W)) u_dclk (
    .clk(clk), .rst_n(rst_n), .phase_cnt(phase_cnt),
    .chg_ph(chg_ph), .rise_ph(rise_ph), .dclk(dclk)
  );
endmodule

// File: rtl/dphase_chk.sv
module dphase_chk #(
  parameter int unsigned DATA_W = dphase_pkg::DEF_DATA_W,
  parameter int unsigned PH_W   = dphase_pkg::DEF_PH_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PH_W-1:0]   phase_cnt,
  input logic [2*PH_W-1:0] phase_cfg,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic              dclk
);
  logic [PH_W-1:0] f_chg;
  logic [PH_W-1:0] f_rise;
  assign f_chg  = phase_cfg[PH_W-1:0];
  assign f_rise = phase_cfg[2*PH_W-1:PH_W];

  assert_dclk_low_at_chg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt == f_chg) |=> !dclk);

  assert_dclk_high_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt == f_rise && f_rise != f_chg) |=> dclk);

  assert_dclk_rise_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $past(phase_cnt == f_rise));

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt != f_chg) |=> ($stable(dout) && $stable(dout_valid)));

  assert_zero_when_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));
endmodule

bind dphase_top dphase_chk #(.DATA_W(DATA_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_cnt(phase_cnt), .phase_cfg(phase_cfg),
  .dout(dout), .dout_valid(dout_valid), .dclk(dclk)
);

// File: tb/sim_dphase_top.sv
`timescale 1ns/1ps
module sim_dphase_top;
  logic        clk;
  logic        rst_n;
  logic [5:0]  phase_cnt;
  logic [11:0] phase_cfg;
  logic        smp_vld;
  logic [13:0] smp_data;
  logic [13:0] dout;
  logic        dout_valid;
  logic        dclk;

  int n_chk;
  int n_bad;
  logic [13:0] hd [0:63];
  bit          hv [0:63];

  dphase_top u0 (
    .clk(clk), .rst_n(rst_n), .phase_cnt(phase_cnt), .phase_cfg(phase_cfg),
    .smp_vld(smp_vld), .smp_data(smp_data),
    .dout(dout), .dout_valid(dout_valid), .dclk(dclk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected word launched at an edge of pixel period pix (R3, R5)
  function automatic logic [14:0] exp_slot(input int pix);
    if (pix >= 16 && hv[pix-16]) return {1'b1, hd[pix-16]};
    return 15'd0;
  endfunction

  task automatic run_case(input logic [5:0] chg, input logic [5:0] rise,
                          input int npix, input int vld_pct, input bit gap);
    logic [13:0] e_d;
    logic        e_v;
    logic        e_c;
    logic [14:0] slot;
    string       tag;
    rst_n = 1'b0; phase_cnt = '0; smp_vld = 1'b1; smp_data = 14'h3fff;
    phase_cfg = {rise, chg};
    repeat (2) @(posedge clk);
    #5;
    chk("R1 dout",  int'(dout), 0);
    chk("R1 valid", int'(dout_valid), 0);
    chk("R1 dclk",  int'(dclk), 0);
    e_d = '0; e_v = 1'b0; e_c = 1'b0;
    tag = (chg == 6'd0) ? "R3,R4,R8" : "R3,R2,R4";
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < npix * 64; t++) begin
      int pix;
      int ph;
      pix = t / 64;
      ph  = t % 64;
      if (t > 0) @(negedge clk);
      phase_cnt = 6'(ph);
      smp_vld   = ($urandom_range(99) < vld_pct);
      if (gap && pix >= 20 && pix <= 23) smp_vld = 1'b0;
      smp_data  = 14'($urandom);
      if (ph == 0) begin
        hv[pix] = smp_vld;
        hd[pix] = smp_data;
      end
      @(posedge clk);
      #5;
      if (6'(ph) == chg) begin
        slot = exp_slot(pix);
        e_v  = slot[14];
        e_d  = slot[13:0];
        e_c  = 1'b0;
      end else if (6'(ph) == rise) begin
        e_c  = 1'b1;
      end
      chk(e_v ? tag : "R5 data", int'(dout), int'(e_d));
      chk("R5 valid", int'(dout_valid), int'(e_v));
      chk((rise == chg) ? "R7 dclk" : "R6,R7 dclk", int'(dclk), int'(e_c));
    end
  endtask

  initial begin
    int seed;
    n_chk = 0;
    n_bad = 0;
    seed = $urandom(32'd20240611);
    run_case(6'd0,  6'd32, 40, 90, 1'b0);   // R8: launch coincides with shift
    run_case(6'd63, 6'd0,  40, 90, 1'b0);   // last phase for data, rise at 0
    run_case(6'd20, 6'd20, 36, 90, 1'b0);   // R7: equal fields keep clock low
    run_case(6'd5,  6'd40, 44, 100, 1'b1);  // R5: gap of invalid samples
    run_case(6'd33, 6'd10, 40, 50, 1'b0);   // rise before change in period
    for (int k = 0; k < 3; k++) begin
      logic [5:0] c;
      logic [5:0] r;
      c = 6'($urandom_range(63));
      r = 6'($urandom_range(63));
      run_case(c, r, 34, 75, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule